// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer with Reset Pulse

This block is a countdown watchdog held in three 8-bit registers: a count register, a control register and a status register. Software starts it by writing a nonzero count, keeps it alive by rewriting the count before it runs out, stops it by writing zero, and reads the count back as the time left. A one-second tick from outside drives the countdown. In minute mode, sixty ticks make one decrement.

When a running count reaches zero, the block drives its active-low watchdog output low for a fixed number of clock cycles and latches an expiry flag in the status register. If the control register enables it, the block also sends a low pulse toward a keyboard-reset line. Optionally, keyboard or mouse activity can reload the count from the last value written, or keyboard activity can cancel the count. The register-access front end and the tick generator sit outside the block.

Top module: `sec_watchdog`

## Requirements
- R1: After reset the count, control and status registers read 0, and both `wdt_n` and `kbrst_n` are high.
- R2: A write with `wr_sel`=0 loads `wr_data` into the count, and the new count appears on `count_q` in the cycle after the write edge. A nonzero value also becomes the shadow value used for reloads.
- R3: In seconds mode (control bit 3 = 0), each `tick` pulse lowers a nonzero count by exactly 1. Ticks have no effect on a count of 0.
- R4: Writing 0 to the count stops the watchdog. The count stays 0 under further ticks, and no expiry occurs.
- R5: A tick that takes the count from 1 to 0 drives `wdt_n` low for exactly 16 clock cycles, beginning in the cycle after that edge. The count then stays 0 until it is rewritten.
- R6: With control bit 1 set, `kbrst_n` goes low over the same 16 cycles as `wdt_n`. With control bit 1 clear, `kbrst_n` stays high.
- R7: With control bit 3 set (minute mode), 60 ticks are needed for each decrement. The prescaler restarts whenever the count is written.
- R8: Status bit 4 (value 0x10) sets on expiry and stays set until software writes the status register with that bit at 0. Writing it as 1 never sets it.
- R9: Keyboard activity while status bit 6 (0x40) is set reloads a running count from the shadow value. Mouse activity while status bit 7 (0x80) is set does the same. With the enable bit clear, or with a count of 0, the activity has no effect.
- R10: With control bit 2 (0x04) set, keyboard activity stops a running count (the count becomes 0) without an expiry.
- R11: A count write in the same cycle as a tick takes priority. The written value is loaded and the tick is discarded.
- R12: A write with `wr_sel`=1 loads the control register, and a write with `wr_sel`=2 loads the status register. A `wr_sel` of 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 control, 2 status |
| wr_data | input | 8 | Write data |
| count_q | output | 8 | Current count (time left) |
| ctrl_q | output | 8 | Control register |
| stat_q | output | 8 | Status register |
| wdt_n | output | 1 | Active-low watchdog output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
Every register result is due one cycle after the edge that samples the write, tick or activity pulse. The expiry pulse starts in that same cycle, and its last low cycle falls 15 cycles later. The driver tasks compute the cycle index for each expected value and queue the value with that index. The monitor compares each queued entry only in that exact cycle, sampling on the falling clock edge. An entry whose cycle has passed without being checked is reported as a failure. This means a pulse that is one cycle short or long, or a decrement that lands one cycle late, is caught.

// File: rtl/sec_watchdog.sv
module sec_watchdog #(
  parameter int DW        = 8,
  parameter int PULSE_LEN = 16,
  parameter int MIN_TICKS = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          kbd_act,
  input  logic          mouse_act,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] count_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic          wdt_n,
  output logic          kbrst_n
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam int MW = $clog2(MIN_TICKS);
  localparam logic [MW-1:0] PRE_LAST = MW'(MIN_TICKS - 1);
  localparam logic [DW-1:0] FLAG = DW'(1) << 4;

  logic [DW-1:0] shadow;
  logic [MW-1:0] pre;
  logic [PW-1:0] pls;

  wire wr_cnt  = wr_en && wr_sel == 2'd0;
  wire wr_ctrl = wr_en && wr_sel == 2'd1;
  wire wr_stat = wr_en && wr_sel == 2'd2;
  wire running = count_q != '0;
  wire cancel  = running && kbd_act && ctrl_q[2];
  wire reload  = running && ((kbd_act && stat_q[6]) || (mouse_act && stat_q[7]));
  wire step    = running && tick && (!ctrl_q[3] || pre == PRE_LAST);
  wire expire  = !wr_cnt && !cancel && !reload && step && count_q == DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      shadow  <= '0;
      pre     <= '0;
    end else if (wr_cnt) begin
      count_q <= wr_data;
      shadow  <= wr_data;
      pre     <= '0;
    end else if (cancel) begin
      count_q <= '0;
      pre     <= '0;
    end else if (reload) begin
      count_q <= shadow;
      pre     <= '0;
    end else if (running && tick) begin
      if (ctrl_q[3] && pre != PRE_LAST) begin
        pre <= pre + 1'b1;
      end else begin
        pre     <= '0;
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      if (wr_stat) stat_q <= (wr_data & ~FLAG) | (wr_data & stat_q & FLAG);
      if (expire)  stat_q[4] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pls <= '0;
    else if (expire)    pls <= PW'(PULSE_LEN);
    else if (pls != '0) pls <= pls - 1'b1;
  end

  assign wdt_n   = pls == '0;
  assign kbrst_n = !(pls != '0 && ctrl_q[1]);
endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          kbd_act,
  input logic          mouse_act,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] count_q,
  input logic [DW-1:0] stat_q,
  input logic          wdt_n,
  input logic          kbrst_n
);
  assert_expiry_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_n) |-> ($past(count_q) == DW'(1) && count_q == '0));

  assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[4]) |-> !wdt_n);

  assert_kbrst_within_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !kbrst_n |-> !wdt_n);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $past(!kbd_act && !mouse_act) && count_q != $past(count_q))
      |-> count_q == $past(count_q) - DW'(1));

  assert_stopped_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count_q) == '0 && !$past(wr_en && wr_sel == 2'd0)) |-> count_q == '0);
endmodule

bind sec_watchdog sec_watchdog_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .kbd_act(kbd_act), .mouse_act(mouse_act),
  .wr_en(wr_en), .wr_sel(wr_sel), .count_q(count_q), .stat_q(stat_q),
  .wdt_n(wdt_n), .kbrst_n(kbrst_n)
);

// File: tb/sec_watchdog_test.sv
`timescale 1ns/1ps
module sec_watchdog_test;
  logic clk = 0, rst_n = 0, tick = 0, kbd_act = 0, mouse_act = 0, wr_en = 0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 0;
  logic [7:0] count_q, ctrl_q, stat_q;
  logic wdt_n, kbrst_n;

  sec_watchdog uut (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  int q_cyc[$];
  int q_fld[$];
  int q_val[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int field(int f);
    case (f)
      0: return int'(count_q);
      1: return int'(wdt_n);
      2: return int'(kbrst_n);
      3: return int'(stat_q);
      default: return int'(ctrl_q);
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] <= cyc) begin
        checks++;
        if (q_cyc[i] < cyc || field(q_fld[i]) != q_val[i]) begin
          failures++;
          $display("FAIL %s field=%0d actual=%0d expected=%0d at cycle %0d",
                   q_tag[i], q_fld[i], field(q_fld[i]), q_val[i], q_cyc[i]);
        end
        q_cyc.delete(i); q_fld.delete(i); q_val.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic expect_at(int off, int f, int v, string tag);
    q_cyc.push_back(cyc + off); q_fld.push_back(f); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic tk();
    tick = 1; step(); tick = 0;
  endtask

  task automatic kbd();
    kbd_act = 1; step(); kbd_act = 0;
  endtask

  task automatic mouse();
    mouse_act = 1; step(); mouse_act = 0;
  endtask

  task automatic finish_run();
    repeat (3) step();
    if (q_cyc.size() != 0) begin
      failures++;
      $display("FAIL pending checks actual=%0d expected=0", q_cyc.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1;
    step();
    expect_at(0, 0, 0, "R1 count");
    expect_at(0, 1, 1, "R1 wdt_n");
    expect_at(0, 2, 1, "R1 kbrst_n");
    expect_at(0, 3, 0, "R1 stat");
    expect_at(0, 4, 0, "R1 ctrl");
    tk();
    expect_at(0, 0, 0, "R3 tick on zero");
    wr(2'd3, 8'h55);
    expect_at(0, 4, 0, "R12 sel3 ctrl");
    expect_at(0, 3, 0, "R12 sel3 stat");
    expect_at(0, 0, 0, "R12 sel3 count");

    wr(2'd0, 8'd5);
    expect_at(0, 0, 5, "R2 load");
    tk(); expect_at(0, 0, 4, "R3 dec");
    tk(); expect_at(0, 0, 3, "R3 dec");
    tick = 1; wr(2'd0, 8'd9); tick = 0;
    expect_at(0, 0, 9, "R11 write beats tick");
    wr(2'd0, 8'd0); expect_at(0, 0, 0, "R4 stop");
    tk(); expect_at(0, 0, 0, "R4 stays"); expect_at(0, 1, 1, "R4 no expiry");

    wr(2'd1, 8'h02); expect_at(0, 4, 2, "R12 ctrl write");
    wr(2'd0, 8'd2);
    tk(); expect_at(0, 0, 1, "R3 dec");
    tk();
    expect_at(0, 1, 0, "R5 pulse start");
    expect_at(15, 1, 0, "R5 pulse last");
    expect_at(16, 1, 1, "R5 pulse end");
    expect_at(0, 2, 0, "R6 kbrst start");
    expect_at(15, 2, 0, "R6 kbrst last");
    expect_at(16, 2, 1, "R6 kbrst end");
    expect_at(0, 3, 8'h10, "R8 flag set");
    expect_at(0, 0, 0, "R5 count zero");
    repeat (18) step();
    tk(); expect_at(0, 0, 0, "R5 stays zero");
    wr(2'd2, 8'h10); expect_at(0, 3, 8'h10, "R8 sticky");
    wr(2'd2, 8'h00); expect_at(0, 3, 0, "R8 cleared");
    wr(2'd2, 8'h10); expect_at(0, 3, 0, "R8 write one no set");

    wr(2'd1, 8'h00);
    wr(2'd0, 8'd1);
    tk();
    expect_at(0, 1, 0, "R6 wdt low");
    expect_at(0, 2, 1, "R6 kbrst masked");
    expect_at(5, 2, 1, "R6 kbrst masked");
    repeat (18) step();
    wr(2'd2, 8'h00);

    wr(2'd1, 8'h08);
    wr(2'd0, 8'd2);
    for (int i = 0; i < 59; i++) tk();
    expect_at(0, 0, 2, "R7 no dec before 60");
    tk(); expect_at(0, 0, 1, "R7 dec at 60");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd0);

    wr(2'd2, 8'h40);
    wr(2'd0, 8'd7);
    tk(); tk(); expect_at(0, 0, 5, "R3 dec");
    kbd(); expect_at(0, 0, 7, "R9 kbd reload");
    tk(); mouse(); expect_at(0, 0, 6, "R9 mouse masked");
    wr(2'd2, 8'h80);
    mouse(); expect_at(0, 0, 7, "R9 mouse reload");
    tk(); kbd(); expect_at(0, 0, 6, "R9 kbd masked");

    wr(2'd1, 8'h04);
    kbd();
    expect_at(0, 0, 0, "R10 cancel");
    expect_at(0, 1, 1, "R10 no pulse");
    expect_at(0, 3, 8'h80, "R10 no flag");
    mouse(); expect_at(0, 0, 0, "R9 no reload when stopped");
    finish_run();
  end
endmodule